// File: doc/BRIEF.md
# Dual-Complement Adder/Subtractor

This block is a purely combinational N-bit signed adder/subtractor. It takes two operands in one shared bit layout and reads them as either one's-complement or two's-complement numbers, chosen by a mode pin. A second pin chooses between the sum and the difference. The block returns the N-bit result, the raw carry out of the sign position and an overflow flag.

Subtraction negates the second operand in the active number system and then adds it to the first. For two's complement, negation is inversion plus one, injected as the carry into bit 0. For one's complement, negation is inversion alone. A carry out of the sign bit is then wrapped back into bit 0. Any binary point is the caller's convention; the logic only sees integers.

Top module: `cmpl_addsub`

## Requirements
- R1: With `ones_mode`=0 and `sub_op`=0, `result` equals `a_in + b_in` modulo 2^N.
- R2: With `ones_mode`=0 and `sub_op`=1, `result` equals `a_in + ~b_in + 1` modulo 2^N, which is `a_in - b_in` modulo 2^N.
- R3: With `ones_mode`=1 and `sub_op`=0, `result` equals `a_in + b_in` modulo 2^N, plus the carry out of bit N-1 added back at bit 0.
- R4: With `ones_mode`=1 and `sub_op`=1, `result` equals `a_in + ~b_in` modulo 2^N, plus the carry out of bit N-1 added back at bit 0.
- R5: `carry_out` is the carry out of bit N-1 in the first addition pass, before any end-around correction. In two's-complement subtraction this pass includes the +1.
- R6: `overflow` is the carry into bit N-1 XOR the carry out of bit N-1, both taken from the first pass. In two's-complement mode, this flag is set exactly when the true signed result lies outside [-2^(N-1), 2^(N-1)-1].
- R7: `overflow` is never set when the sign bit of `a_in` differs from the sign bit of the effective second operand. The effective second operand is `b_in` for addition and `~b_in` for subtraction.
- R8: In one's-complement mode, subtracting any value from itself yields negative zero (all ones). This value is passed through unchanged, and `overflow` is 0.
- R9: For N=9 in two's-complement addition, 0b010011011 plus itself gives 0b100110110 with `overflow`=1 and `carry_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | N | First operand (minuend for subtraction) |
| b_in | input | N | Second operand (subtrahend for subtraction) |
| ones_mode | input | 1 | 1 = one's complement, 0 = two's complement |
| sub_op | input | 1 | 1 = a_in - b_in, 0 = a_in + b_in |
| result | output | N | Sum or difference |
| carry_out | output | 1 | Raw carry out of the sign position, first pass |
| overflow | output | 1 | Carry into sign XOR carry out of sign |

## Verification
The bench sweeps every operand pair in both modes and both operations at N=5, and compares each output with an integer model. One case is a two's-complement subtraction of zero. There the +1 must produce a carry out; a design that negated by inversion alone would drop that carry and give a result one too low. A second case adds a one's-complement operand to negative zero. A design that skipped the end-around carry would return a result off by one there. A design that took its carries after the wrap would report overflow wrongly in that same case. A last case is x minus x in one's-complement mode, which must give all ones. A design that normalised negative zero would return 0 there instead.

// File: rtl/cmpl_addsub.sv
module cmpl_addsub #(
  parameter int N = 5
) (
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         ones_mode,
  input  logic         sub_op,
  output logic [N-1:0] result,
  output logic         carry_out,
  output logic         overflow
);
  localparam int LOW = N - 1;

  logic [N-1:0]   b_eff;
  logic           inj;
  logic [LOW-1:0] low_sum;
  logic           sign_sum;
  logic           c_into_sign;
  logic           c_from_sign;
  logic           wrap;

  assign b_eff = sub_op ? ~b_in : b_in;
  assign inj   = sub_op & ~ones_mode;

  assign {c_into_sign, low_sum} = {1'b0, a_in[LOW-1:0]} + {1'b0, b_eff[LOW-1:0]}
                                + {{LOW{1'b0}}, inj};
  assign {c_from_sign, sign_sum} = {1'b0, a_in[N-1]} + {1'b0, b_eff[N-1]}
                                 + {1'b0, c_into_sign};

  assign wrap      = ones_mode & c_from_sign;
  assign result    = {sign_sum, low_sum} + {{LOW{1'b0}}, wrap};
  assign carry_out = c_from_sign;
  assign overflow  = c_into_sign ^ c_from_sign;

  always_comb begin
    a_r1_twos_add: assert (ones_mode || sub_op || result == a_in + b_in);
    a_r2_twos_sub: assert (ones_mode || !sub_op || result + b_in == a_in);
    a_r3_ones_add: assert (!ones_mode || sub_op
                           || result == a_in + b_in + {{LOW{1'b0}}, carry_out});
    a_r7_mixed_sign: assert (a_in[N-1] == b_eff[N-1] || !overflow);
    a_r8_neg_zero: assert (!(ones_mode && sub_op && a_in == b_in)
                           || (result == {N{1'b1}} && !overflow));
  end
endmodule

// File: tb/cmpl_addsub_tb_top.sv
module cmpl_addsub_tb_top;
  localparam int N = 5;
  localparam int M = 9;

  typedef struct {
    int a; int b; bit om; bit sb;
    int sum; bit cout; bit ovf;
  } item_t;

  logic clk = 0, rst = 1;
  always #5 clk = ~clk;

  logic [N-1:0] a_in = '0, b_in = '0, result;
  logic ones_mode = 0, sub_op = 0, carry_out, overflow;
  logic [M-1:0] a9 = '0, b9 = '0, r9;
  logic c9, o9;

  int checks = 0, failures = 0;
  item_t q[$];
  bit drive_done = 0;

  cmpl_addsub #(.N(N)) dut_i (.a_in(a_in), .b_in(b_in), .ones_mode(ones_mode),
    .sub_op(sub_op), .result(result), .carry_out(carry_out), .overflow(overflow));
  cmpl_addsub #(.N(M)) dut9_i (.a_in(a9), .b_in(b9), .ones_mode(1'b0),
    .sub_op(1'b0), .result(r9), .carry_out(c9), .overflow(o9));

  function automatic item_t model(int n, int a, int b, bit om, bit sb);
    item_t it;
    int mask = (1 << n) - 1;
    int op2, tot, c, sa, so, sr, va, vb, r;
    it.a = a; it.b = b; it.om = om; it.sb = sb;
    if (om) begin
      op2 = sb ? mask - b : b;
      tot = a + op2;
      c = (tot >> n) & 1;
      it.sum = (tot + c) & mask;
      it.cout = c[0];
      sa = (a >> (n-1)) & 1; so = (op2 >> (n-1)) & 1; sr = (tot >> (n-1)) & 1;
      it.ovf = (sa == so) && (sr != sa);
    end else begin
      op2 = sb ? (1 << n) - b : b;
      tot = a + op2;
      it.sum = tot & mask;
      it.cout = ((tot >> n) & 1) != 0;
      va = (a >> (n-1)) != 0 ? a - (1 << n) : a;
      vb = (b >> (n-1)) != 0 ? b - (1 << n) : b;
      r = sb ? va - vb : va + vb;
      it.ovf = (r > (1 << (n-1)) - 1) || (r < -(1 << (n-1)));
    end
    return it;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int a, int b, bit om, bit sb);
    @(posedge clk); #1;
    a_in = a[N-1:0]; b_in = b[N-1:0]; ones_mode = om; sub_op = sb;
    q.push_back(model(N, a, b, om, sb));
  endtask

  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      item_t e;
      string rs, ro;
      e = q.pop_front();
      rs = e.om ? (e.sb ? "R4" : "R3") : (e.sb ? "R2" : "R1");
      check(int'(result) == e.sum, rs, int'(result), e.sum);
      check(carry_out == e.cout, "R5", int'(carry_out), int'(e.cout));
      ro = (((e.a >> (N-1)) & 1) != (((e.sb ? ~e.b : e.b) >> (N-1)) & 1)) ? "R7" : "R6";
      check(overflow == e.ovf, ro, int'(overflow), int'(e.ovf));
      if (e.om && e.sb && e.a == e.b) begin
        check(result == '1 && !overflow, "R8", int'(result), (1 << N) - 1);
      end
    end
  end

  initial begin
    #2000000;
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 0;
    drive(0, 0, 0, 0);
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < (1 << N); a++)
          for (int b = 0; b < (1 << N); b++)
            drive(a, b, m[0], s[0]);
    @(posedge clk); @(posedge clk);
    wait (q.size() == 0);
    a9 = 9'b010011011; b9 = 9'b010011011;
    #3;
    check(r9 == 9'b100110110, "R9", int'(r9), 310);
    check(o9 == 1'b1, "R9", int'(o9), 1);
    check(c9 == 1'b0, "R9", int'(c9), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule